// File: doc/BRIEF.md
# Nonvolatile Write Cycle Sequencer

This block sits behind a serial-bus slave front end of a small byte-wide nonvolatile memory. Once the front end has accepted a write transaction, the block holds the one or two data bytes of that transaction together with their array addresses. When the bus Stop condition arrives, it runs the timed erase/write cycle and raises a busy flag for the whole cycle. The bus itself stays free during this time, because the block never touches the bus lines.

The cycle length comes from one of two sources. The choice is made separately for each transaction, from the level of the TEST pin when the front end marks the 8th bit of the device-select byte.

- **Internal source:** ticks of an on-chip oscillator pass through a divide-by-128 prescaler. Each byte costs a parameterised number of prescaled units.
- **External source:** the rising edges on TEST are counted. A one-byte cycle takes 257 edges and a two-byte cycle takes 513.

When the final count is reached, the held bytes are written to the array port, one per clock, in the order they were received.

Top module: `nv_write_seq`

## Requirements
- R1: After reset, `busy_o` and `wr_en_o` are low, and they stay low until a Stop starts a cycle.
- R2: On a `sel_bit8_i` strobe while idle, the level of `test_i` picks the timebase for the next cycle: 1 selects the internal oscillator and 0 selects external TEST pulses. Only the selected source advances the cycle; activity on the other source has no effect on its length.
- R3: A `stop_i` strobe while idle with at least one byte held raises `busy_o` in the next cycle. A `stop_i` strobe with no byte held leaves `busy_o` low.
- R4: At most two bytes are held per transaction. Data strobes beyond the second are dropped, and the cycle length and the writes are those of two bytes.
- R5: In external mode, the first array write strobe appears in the cycle after the (256·n+1)-th rising edge of `test_i` seen while busy, where n is the number of held bytes: 257 edges for one byte and 513 for two.
- R6: In internal mode, the first array write strobe appears in the cycle after the (128·INT_TICKS·n)-th `osc_tick_i` seen while busy.
- R7: At the end of a cycle, `wr_en_o` pulses for n consecutive cycles with the held address/data pairs in order of receipt. `busy_o` stays high through the last pulse and falls in the cycle after it.
- R8: While `busy_o` is high, the select, data and Stop strobes are ignored. A byte offered during a cycle is not held for a later Stop.
- R9: A data strobe in the same cycle as `stop_i` is held and included in the cycle that this Stop starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_bit8_i | input | 1 | Strobe: 8th bit of the device-select byte has been taken in; starts a new transaction |
| test_i | input | 1 | TEST pin level, already synchronous to `clk_i` |
| osc_tick_i | input | 1 | One-cycle tick from the internal programming oscillator |
| byte_we_i | input | 1 | Strobe: the front end has accepted a data byte |
| byte_addr_i | input | ADDR_W | Array address of the offered byte |
| byte_data_i | input | DATA_W | Offered data byte |
| stop_i | input | 1 | Strobe: Stop condition seen on the bus |
| busy_o | output | 1 | Programming cycle in progress |
| wr_en_o | output | 1 | Array write strobe |
| wr_addr_o | output | ADDR_W | Array write address |
| wr_data_o | output | DATA_W | Array write data |

## Verification
Two events can land on the same clock edge here:

- **Data strobe and Stop strobe together.** The bench provokes this by issuing the last data byte in the same cycle as `stop_i`. It judges the result by requiring a two-byte cycle length and two write pulses, with the second pulse carrying that byte.
- **Both timebases active together.** During every cycle the bench keeps both `osc_tick_i` and TEST pulses running. It counts only the events of the selected source up to the first write pulse and compares that count with the value computed from R5 or R6.

A data strobe, a select strobe and a Stop issued together in the middle of a cycle must leave the cycle untouched. A later bare Stop must not start another cycle.

// File: rtl/nvws_pkg.sv
package nvws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_COMMIT = 2'd2
  } nvws_state_e;

endpackage

// File: rtl/nvws_latch.sv
// Pending byte slots and per-transaction timebase selection.
module nvws_latch #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 2,
  parameter int CNT_W     = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              accept_i,
  input  logic                              clear_i,
  input  logic                              sel_i,
  input  logic                              test_i,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 data_i,
  output logic                              ext_mode_o,
  output logic [CNT_W-1:0]                  cnt_o,
  output logic [CNT_W-1:0]                  cnt_nxt_o,
  output logic [MAX_BYTES-1:0][ADDR_W-1:0]  slot_addr_o,
  output logic [MAX_BYTES-1:0][DATA_W-1:0]  slot_data_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             take;
  logic             ext_q;

  assign take      = accept_i && we_i && !sel_i && (cnt_q < CNT_W'(MAX_BYTES));
  assign cnt_nxt_o = take ? cnt_q + CNT_W'(1) : cnt_q;
  assign cnt_o     = cnt_q;
  assign ext_mode_o = ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ext_q <= 1'b0;
    end else begin
      if (clear_i) begin
        cnt_q <= '0;
      end else if (accept_i && sel_i) begin
        cnt_q <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      // TEST low selects external pulse counting
      if (accept_i && sel_i) ext_q <= ~test_i;
    end
  end

  for (genvar s = 0; s < MAX_BYTES; s++) begin : g_slot
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
        d_q <= '0;
      end else if (take && (cnt_q == CNT_W'(s))) begin
        a_q <= addr_i;
        d_q <= data_i;
      end
    end
    assign slot_addr_o[s] = a_q;
    assign slot_data_o[s] = d_q;
  end

endmodule

// File: rtl/nvws_timer.sv
// Cycle timebase: prescaled oscillator or external TEST edges.
module nvws_timer #(
  parameter int PRESCALE  = 128,
  parameter int INT_TICKS = 64,
  parameter int EXT_UNIT  = 256,
  parameter int EXT_EXTRA = 1,
  parameter int MAX_BYTES = 2,
  parameter int CNT_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ext_mode_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             osc_tick_i,
  input  logic             test_i,
  output logic             done_o
);

  localparam int EXT_MAX = EXT_UNIT * MAX_BYTES + EXT_EXTRA;
  localparam int INT_MAX = INT_TICKS * MAX_BYTES;
  localparam int MAX_TGT = (EXT_MAX > INT_MAX) ? EXT_MAX : INT_MAX;
  localparam int TGT_W   = $clog2(MAX_TGT + 1);
  localparam int PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             test_q;
  logic             rise;
  logic [PRE_W-1:0] pre_q;
  logic             int_evt;
  logic             evt;
  logic [TGT_W-1:0] ev_cnt_q;
  logic [TGT_W-1:0] target;

  assign rise    = test_i && !test_q;
  assign int_evt = osc_tick_i && (pre_q == PRE_W'(PRESCALE - 1));
  assign evt     = run_i && (ext_mode_i ? rise : int_evt);
  assign target  = ext_mode_i
                 ? TGT_W'(EXT_UNIT) * TGT_W'(nbytes_i) + TGT_W'(EXT_EXTRA)
                 : TGT_W'(INT_TICKS) * TGT_W'(nbytes_i);
  assign done_o  = evt && (ev_cnt_q == target - TGT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_q   <= 1'b0;
      pre_q    <= '0;
      ev_cnt_q <= '0;
    end else begin
      test_q <= test_i;
      if (!run_i || ext_mode_i) begin
        pre_q <= '0;
      end else if (osc_tick_i) begin
        pre_q <= (pre_q == PRE_W'(PRESCALE - 1)) ? '0 : pre_q + PRE_W'(1);
      end
      if (!run_i) begin
        ev_cnt_q <= '0;
      end else if (evt) begin
        ev_cnt_q <= ev_cnt_q + TGT_W'(1);
      end
    end
  end

endmodule

// File: rtl/nvws_ctrl.sv
// Cycle sequencing: idle, timing, ordered commit.
module nvws_ctrl #(
  parameter int MAX_BYTES = 2,
  parameter int CNT_W     = 2,
  parameter int IDX_W     = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] pend_nxt_i,
  input  logic [CNT_W-1:0] pend_cnt_i,
  input  logic             done_i,
  output logic             idle_o,
  output logic             run_o,
  output logic             commit_o,
  output logic             clear_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o
);
  import nvws_pkg::*;

  nvws_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  assign last     = (CNT_W'(idx_q) + CNT_W'(1)) == pend_cnt_i;
  assign idle_o   = (state_q == ST_IDLE);
  assign run_o    = (state_q == ST_COUNT);
  assign commit_o = (state_q == ST_COMMIT);
  assign clear_o  = commit_o && last;
  assign idx_o    = idx_q;
  assign busy_o   = !idle_o;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        idx_d = '0;
        if (stop_i && (pend_nxt_i != '0)) state_d = ST_COUNT;
      end
      ST_COUNT: begin
        idx_d = '0;
        if (done_i) state_d = ST_COMMIT;
      end
      ST_COMMIT: begin
        if (last) begin
          state_d = ST_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/nv_write_seq.sv
module nv_write_seq #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 2,
  parameter int PRESCALE  = 128,
  parameter int INT_TICKS = 64,
  parameter int EXT_UNIT  = 256,
  parameter int EXT_EXTRA = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_bit8_i,
  input  logic              test_i,
  input  logic              osc_tick_i,
  input  logic              byte_we_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic                             idle, run, commit, clear, done, ext_mode;
  logic [CNT_W-1:0]                 pend_cnt, pend_nxt;
  logic [IDX_W-1:0]                 idx;
  logic [MAX_BYTES-1:0][ADDR_W-1:0] slot_addr;
  logic [MAX_BYTES-1:0][DATA_W-1:0] slot_data;

  nvws_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
  ) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (idle),
    .clear_i     (clear),
    .sel_i       (sel_bit8_i),
    .test_i      (test_i),
    .we_i        (byte_we_i),
    .addr_i      (byte_addr_i),
    .data_i      (byte_data_i),
    .ext_mode_o  (ext_mode),
    .cnt_o       (pend_cnt),
    .cnt_nxt_o   (pend_nxt),
    .slot_addr_o (slot_addr),
    .slot_data_o (slot_data)
  );

  nvws_timer #(
    .PRESCALE(PRESCALE), .INT_TICKS(INT_TICKS), .EXT_UNIT(EXT_UNIT),
    .EXT_EXTRA(EXT_EXTRA), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .ext_mode_i (ext_mode),
    .nbytes_i   (pend_cnt),
    .osc_tick_i (osc_tick_i),
    .test_i     (test_i),
    .done_o     (done)
  );

  nvws_ctrl #(
    .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_i     (stop_i),
    .pend_nxt_i (pend_nxt),
    .pend_cnt_i (pend_cnt),
    .done_i     (done),
    .idle_o     (idle),
    .run_o      (run),
    .commit_o   (commit),
    .clear_o    (clear),
    .idx_o      (idx),
    .busy_o     (busy_o)
  );

  assign wr_en_o   = commit;
  assign wr_addr_o = slot_addr[idx];
  assign wr_data_o = slot_data[idx];

endmodule

// File: rtl/nv_write_seq_chk.sv
module nv_write_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_i,
  input logic busy_o,
  input logic wr_en_o
);

  // R3: busy only rises after a Stop strobe
  a_r3_busy_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  // R7: write strobes only inside a busy window
  a_r7_write_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);

  // R7: busy ends right after the final write strobe
  a_r7_fall_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(wr_en_o));

  // R4: never more than two strobes in a row
  a_r4_two_writes_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |=> !wr_en_o);

  // R8: a Stop during timing does not end the cycle
  a_r8_stop_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wr_en_o && stop_i) |=> busy_o);

endmodule

bind nv_write_seq nv_write_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .stop_i  (stop_i),
  .busy_o  (busy_o),
  .wr_en_o (wr_en_o)
);

// File: tb/nv_write_seq_bench.sv
`timescale 1ns/1ps
module nv_write_seq_bench;

  localparam int INT_TICKS = 3;
  localparam int PRESCALE  = 128;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_bit8_i = 1'b0;
  logic       test_i = 1'b1;
  logic       osc_tick_i = 1'b0;
  logic       byte_we_i = 1'b0;
  logic [7:0] byte_addr_i = '0;
  logic [7:0] byte_data_i = '0;
  logic       stop_i = 1'b0;
  logic       busy_o, wr_en_o;
  logic [7:0] wr_addr_o, wr_data_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit prev_test = 1'b1;

  always #4 clk_i = ~clk_i;

  nv_write_seq #(.INT_TICKS(INT_TICKS), .PRESCALE(PRESCALE)) u_nv_write_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_bit8_i(sel_bit8_i), .test_i(test_i),
    .osc_tick_i(osc_tick_i), .byte_we_i(byte_we_i), .byte_addr_i(byte_addr_i),
    .byte_data_i(byte_data_i), .stop_i(stop_i), .busy_o(busy_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [7:0] dat(input int base, input int i);
    return 8'((base * 29 + i * 71 + 5) ^ 8'h5A);
  endfunction

  // Start a transaction: select strobe with TEST level (low = external).
  task automatic select(input bit ext);
    test_i = ext ? 1'b0 : 1'b1;
    prev_test = test_i;
    sel_bit8_i = 1'b1;
    @(negedge clk_i);
    sel_bit8_i = 1'b0;
  endtask

  // Full write cycle; nb bytes offered, last one optionally with Stop.
  task automatic run_case(input bit ext, input int nb, input bit stop_last,
                          input int base, input bit poke);
    int n, tgt, evc, ph, guard;
    n = (nb > 2) ? 2 : nb;
    tgt = ext ? (256 * n + 1) : (PRESCALE * INT_TICKS * n);
    select(ext);
    for (int i = 0; i < nb; i++) begin
      byte_we_i = 1'b1;
      byte_addr_i = 8'(base + i);
      byte_data_i = dat(base, i);
      if (i == nb - 1 && stop_last) stop_i = 1'b1;
      @(negedge clk_i);
      byte_we_i = 1'b0;
      stop_i = 1'b0;
    end
    if (!stop_last) begin
      stop_i = 1'b1;
      @(negedge clk_i);
      stop_i = 1'b0;
    end
    chk(busy_o == 1'b1, ext ? "R3 ext start" : "R3 int start", busy_o, 1);
    evc = 0; ph = 0; guard = 0;
    while (!wr_en_o && guard < 20000) begin
      // Both sources active; only the selected one should count (R2).
      osc_tick_i = 1'b1;
      test_i = (ph % 4) < 2;
      if (ext && test_i && !prev_test) evc++;
      if (!ext) evc++;
      prev_test = test_i;
      ph++;
      if (poke && guard == 7) begin
        // R8: strobes while busy
        sel_bit8_i = 1'b1; byte_we_i = 1'b1; stop_i = 1'b1;
        byte_addr_i = 8'hEE; byte_data_i = 8'hEE;
      end
      @(negedge clk_i);
      sel_bit8_i = 1'b0; byte_we_i = 1'b0; stop_i = 1'b0;
      guard++;
      if (!wr_en_o && !busy_o) begin
        chk(1'b0, "R7 busy held", busy_o, 1);
        guard = 20000;
      end
    end
    osc_tick_i = 1'b0;
    if (ext) chk(evc == tgt, "R5 edge count", evc, tgt);
    else     chk(evc == tgt, "R6 tick count", evc, tgt);
    chk(wr_en_o && wr_addr_o == 8'(base) && wr_data_o == dat(base, 0),
        "R7 first write", int'(wr_data_o), int'(dat(base, 0)));
    @(negedge clk_i);
    if (n == 2) begin
      chk(wr_en_o && wr_addr_o == 8'(base + 1) && wr_data_o == dat(base, 1),
          "R4 R9 second write", int'(wr_data_o), int'(dat(base, 1)));
      @(negedge clk_i);
    end
    chk(!wr_en_o && !busy_o, "R7 end of cycle", int'({busy_o, wr_en_o}), 0);
  endtask

  task automatic idle_check(input string req, input int cycles);
    bit seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk_i);
      if (busy_o || wr_en_o) seen = 1'b1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !wr_en_o, "R1 reset", int'({busy_o, wr_en_o}), 0);
    rst_ni = 1'b1;
    idle_check("R1 quiet after reset", 4);

    // R3: Stop with nothing held
    select(1'b0);
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    idle_check("R3 empty stop", 6);

    // Sweep: mode x byte count (R2 R4 R5 R6 R7)
    for (int e = 0; e < 2; e++) begin
      for (int nb = 1; nb <= 3; nb++) begin
        run_case(e[0], nb, 1'b0, 16 * nb + 64 * e, 1'b0);
      end
    end

    // R9: last byte together with Stop, both modes
    run_case(1'b1, 2, 1'b1, 200, 1'b0);
    run_case(1'b0, 2, 1'b1, 255, 1'b0);
    run_case(1'b0, 1, 1'b1, 9, 1'b0);

    // R8: strobes while busy are dropped; a bare Stop after must not start
    run_case(1'b1, 1, 1'b0, 40, 1'b1);
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    idle_check("R8 byte offered while busy not held", 6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule